// File: doc/BRIEF.md
# Bank Lease Lifetime Predictor

This block keeps one adaptive lease length for a single L2 bank. Every load the bank serves is granted a lease of the length the block currently outputs, and all addresses in the bank share that one value. The block sees only what happens inside its own bank, and it learns from three one-cycle strobes that the bank's control logic raises.

A load that arrives after its line's lease has already run out suggests that leases are too short, so the prediction grows. A store or an eviction that finds a line whose lease is still running suggests that leases are too long, because that write or replacement must wait for the lease or work around it. In that case the prediction shrinks. If growth and shrink evidence arrive in the same cycle, the shrink wins. The value is clamped between a floor and a ceiling and never wraps. The floor, the ceiling, the reset value and both step sizes are parameters.

Top module: `lease_pred`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `lease_o` equals the parameter LIFE_INIT.
- R2: An expired-load strobe with neither shrink strobe raised makes `lease_o` rise by STEP_UP at the next clock edge, unless the ceiling clamps it.
- R3: A live-store strobe alone makes `lease_o` fall by STEP_DN at the next clock edge, unless the floor clamps it.
- R4: A live-eviction strobe alone makes `lease_o` fall by STEP_DN at the next clock edge, unless the floor clamps it.
- R5: A live-store strobe and a live-eviction strobe in the same cycle lower `lease_o` by a single STEP_DN, not by two steps.
- R6: When the expired-load strobe and either shrink strobe are high together, only the shrink is applied and the growth is ignored.
- R7: In a cycle with no strobe, `lease_o` keeps its value.
- R8: A step up that would pass LIFE_MAX leaves `lease_o` exactly at LIFE_MAX. Further growth at the ceiling keeps it there.
- R9: A step down that would pass below LIFE_MIN leaves `lease_o` exactly at LIFE_MIN. Further shrinking at the floor keeps it there.
- R10: `lease_o` always lies within LIFE_MIN to LIFE_MAX inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_expired_i | input | 1 | A load found its line's lease already over (grow evidence) |
| store_live_i | input | 1 | A store hit a line whose lease is still running (shrink evidence) |
| evict_live_i | input | 1 | An eviction hit a line whose lease is still running (shrink evidence) |
| lease_o | output | LIFE_W | Current predicted lease lifetime granted to loads |

## Verification
The bench builds the block with a 6-bit value, a floor of 3, a ceiling of 20, a reset value of 10, an up step of 3 and a down step of 2. With these values both clamps are reached within a few strobes. Neither step divides the range evenly, so a step partly crosses a limit and the clamp logic must cut it short instead of landing on the limit by chance. The unequal steps also show which direction was applied when strobes collide, and a two-step decrease from a double shrink differs from a single one.

// File: rtl/lease_pred_pkg.sv
package lease_pred_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_GROW   = 2'd1,
      ACT_SHRINK = 2'd2
   } lease_act_e;

endpackage

// File: rtl/lease_evt_arbiter.sv
module lease_evt_arbiter
   import lease_pred_pkg::*;
(
   input  logic       grow_req_i,
   input  logic       shrink_a_i,
   input  logic       shrink_b_i,
   output lease_act_e act_o
);

   logic shrink_any;

   assign shrink_any = shrink_a_i | shrink_b_i;

   always_comb begin
      if (shrink_any)
         act_o = ACT_SHRINK;
      else if (grow_req_i)
         act_o = ACT_GROW;
      else
         act_o = ACT_HOLD;
   end

endmodule

// File: rtl/lease_sat_step.sv
module lease_sat_step
   import lease_pred_pkg::*;
#(
   parameter int LIFE_W  = 8,
   parameter int LIFE_MIN = 1,
   parameter int LIFE_MAX = 250,
   parameter int STEP_UP = 1,
   parameter int STEP_DN = 1
) (
   input  logic [LIFE_W-1:0] cur_i,
   input  lease_act_e        act_i,
   output logic [LIFE_W-1:0] nxt_o
);

   localparam logic [LIFE_W-1:0] MAX_V = LIFE_W'(LIFE_MAX);
   localparam logic [LIFE_W-1:0] MIN_V = LIFE_W'(LIFE_MIN);
   localparam logic [LIFE_W-1:0] UP_V  = LIFE_W'(STEP_UP);
   localparam logic [LIFE_W-1:0] DN_V  = LIFE_W'(STEP_DN);

   logic [LIFE_W-1:0] grown;
   logic [LIFE_W-1:0] shrunk;

   generate
      if (STEP_UP == 1) begin : g_up_unit
         always_comb begin
            if (cur_i >= MAX_V)
               grown = MAX_V;
            else
               grown = cur_i + 1'b1;
         end
      end else begin : g_up_wide
         logic [LIFE_W-1:0] headroom;
         always_comb begin
            headroom = (cur_i >= MAX_V) ? '0 : (MAX_V - cur_i);
            if (headroom < UP_V)
               grown = MAX_V;
            else
               grown = cur_i + UP_V;
         end
      end

      if (STEP_DN == 1) begin : g_dn_unit
         always_comb begin
            if (cur_i <= MIN_V)
               shrunk = MIN_V;
            else
               shrunk = cur_i - 1'b1;
         end
      end else begin : g_dn_wide
         logic [LIFE_W-1:0] legroom;
         always_comb begin
            legroom = (cur_i <= MIN_V) ? '0 : (cur_i - MIN_V);
            if (legroom < DN_V)
               shrunk = MIN_V;
            else
               shrunk = cur_i - DN_V;
         end
      end
   endgenerate

   always_comb begin
      unique case (act_i)
         ACT_GROW:   nxt_o = grown;
         ACT_SHRINK: nxt_o = shrunk;
         default:    nxt_o = cur_i;
      endcase
   end

endmodule

// File: rtl/lease_pred.sv
module lease_pred
   import lease_pred_pkg::*;
#(
   parameter int LIFE_W    = 8,
   parameter int LIFE_MIN  = 1,
   parameter int LIFE_MAX  = 250,
   parameter int LIFE_INIT = 10,
   parameter int STEP_UP   = 1,
   parameter int STEP_DN   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_expired_i,
   input  logic              store_live_i,
   input  logic              evict_live_i,
   output logic [LIFE_W-1:0] lease_o
);

   localparam logic [LIFE_W-1:0] INIT_V = LIFE_W'(LIFE_INIT);

   generate
      if (LIFE_W < 2 || LIFE_W > 31) begin : g_bad_w
         $error("lease_pred: LIFE_W out of supported range");
      end
      if (LIFE_MIN < 0 || LIFE_MIN > LIFE_MAX) begin : g_bad_min
         $error("lease_pred: LIFE_MIN must not exceed LIFE_MAX");
      end
      if (LIFE_MAX >= (1 << LIFE_W)) begin : g_bad_max
         $error("lease_pred: LIFE_MAX does not fit in LIFE_W bits");
      end
      if (LIFE_INIT < LIFE_MIN || LIFE_INIT > LIFE_MAX) begin : g_bad_init
         $error("lease_pred: LIFE_INIT outside the clamp range");
      end
      if (STEP_UP < 1 || STEP_UP >= (1 << LIFE_W)) begin : g_bad_up
         $error("lease_pred: STEP_UP out of range");
      end
      if (STEP_DN < 1 || STEP_DN >= (1 << LIFE_W)) begin : g_bad_dn
         $error("lease_pred: STEP_DN out of range");
      end
   endgenerate

   lease_act_e        act;
   logic [LIFE_W-1:0] lease_q;
   logic [LIFE_W-1:0] lease_d;

   lease_evt_arbiter u_arb (
      .grow_req_i (load_expired_i),
      .shrink_a_i (store_live_i),
      .shrink_b_i (evict_live_i),
      .act_o      (act)
   );

   lease_sat_step #(
      .LIFE_W   (LIFE_W),
      .LIFE_MIN (LIFE_MIN),
      .LIFE_MAX (LIFE_MAX),
      .STEP_UP  (STEP_UP),
      .STEP_DN  (STEP_DN)
   ) u_step (
      .cur_i (lease_q),
      .act_i (act),
      .nxt_o (lease_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         lease_q <= INIT_V;
      else
         lease_q <= lease_d;
   end

   assign lease_o = lease_q;

endmodule

// File: rtl/lease_pred_chk.sv
module lease_pred_chk #(
   parameter int LIFE_W    = 8,
   parameter int LIFE_MIN  = 1,
   parameter int LIFE_MAX  = 250,
   parameter int LIFE_INIT = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_expired_i,
   input logic              store_live_i,
   input logic              evict_live_i,
   input logic [LIFE_W-1:0] lease_o
);

   logic shrink_ev;
   logic grow_only;
   logic quiet;

   assign shrink_ev = store_live_i | evict_live_i;
   assign grow_only = load_expired_i & ~shrink_ev;
   assign quiet     = ~load_expired_i & ~shrink_ev;

   assert_reset_init_R1: assert property (@(posedge clk)
      !rst_n |=> (lease_o == LIFE_W'(LIFE_INIT)));

   assert_grow_not_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grow_only |=> (lease_o >= $past(lease_o)));

   assert_shrink_not_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
      shrink_ev |=> (lease_o <= $past(lease_o)));

   assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> $stable(lease_o));

   assert_ceiling_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (grow_only && lease_o == LIFE_W'(LIFE_MAX)) |=> (lease_o == LIFE_W'(LIFE_MAX)));

   assert_floor_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (shrink_ev && lease_o == LIFE_W'(LIFE_MIN)) |=> (lease_o == LIFE_W'(LIFE_MIN)));

   assert_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lease_o >= LIFE_W'(LIFE_MIN)) && (lease_o <= LIFE_W'(LIFE_MAX)));

endmodule

bind lease_pred lease_pred_chk #(
   .LIFE_W    (LIFE_W),
   .LIFE_MIN  (LIFE_MIN),
   .LIFE_MAX  (LIFE_MAX),
   .LIFE_INIT (LIFE_INIT)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .load_expired_i (load_expired_i),
   .store_live_i   (store_live_i),
   .evict_live_i   (evict_live_i),
   .lease_o        (lease_o)
);

// File: tb/lease_pred_test.sv
module lease_pred_test;

   localparam int CLK_PERIOD = 10;
   localparam int W     = 6;
   localparam int LMIN  = 3;
   localparam int LMAX  = 20;
   localparam int LINIT = 10;
   localparam int UP    = 3;
   localparam int DN    = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ld = 1'b0;
   logic         st = 1'b0;
   logic         ev = 1'b0;
   logic [W-1:0] lease;

   int n_tests = 0;
   int n_fail  = 0;
   int expv    = LINIT;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lease_pred #(
      .LIFE_W    (W),
      .LIFE_MIN  (LMIN),
      .LIFE_MAX  (LMAX),
      .LIFE_INIT (LINIT),
      .STEP_UP   (UP),
      .STEP_DN   (DN)
   ) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .load_expired_i (ld),
      .store_live_i   (st),
      .evict_live_i   (ev),
      .lease_o        (lease)
   );

   function automatic int model_next(int cur, bit l, bit s, bit e);
      if (s || e) return (cur - DN < LMIN) ? LMIN : cur - DN;
      if (l)      return (cur + UP > LMAX) ? LMAX : cur + UP;
      return cur;
   endfunction

   function automatic string tag_of(int cur, bit l, bit s, bit e);
      if (l && (s || e))   return "R6";
      if (s && e)          return "R5";
      if (s || e) begin
         if (cur - DN < LMIN) return "R9";
         return s ? "R3" : "R4";
      end
      if (l) begin
         if (cur + UP > LMAX) return "R8";
         return "R2";
      end
      return "R7";
   endfunction

   task automatic check(string req, int act, int exp_v);
      n_tests++;
      if (act != exp_v) begin
         n_fail++;
         $display("FAIL %s: lease actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   // called just after a falling edge; applies strobes for one cycle
   task automatic cyc(bit l, bit s, bit e);
      string t;
      t  = tag_of(expv, l, s, e);
      ld = l; st = s; ev = e;
      @(posedge clk);
      expv = model_next(expv, l, s, e);
      @(negedge clk);
      ld = 1'b0; st = 1'b0; ev = 1'b0;
      check(t, int'(lease), expv);
      n_tests++;
      if (int'(lease) < LMIN || int'(lease) > LMAX) begin
         n_fail++;
         $display("FAIL R10: lease actual %0d expected within %0d..%0d", lease, LMIN, LMAX);
      end
   endtask

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h1EA5E);
      repeat (3) @(negedge clk);
      check("R1", int'(lease), LINIT);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(lease), LINIT);
      expv = LINIT;

      // R7 quiet cycles
      cyc(0, 0, 0);
      cyc(0, 0, 0);
      // R2 single growth
      cyc(1, 0, 0);
      // R3 / R4 single shrinks
      cyc(0, 1, 0);
      cyc(0, 0, 1);
      // R5 double shrink counts once
      cyc(0, 1, 1);
      // R6 collisions
      cyc(1, 1, 0);
      cyc(1, 0, 1);
      cyc(1, 1, 1);
      // R8 climb to the ceiling, partial step, then stay
      for (int i = 0; i < 8; i++) cyc(1, 0, 0);
      check("R8", int'(lease), LMAX);
      cyc(1, 0, 0);
      // R9 fall to the floor, partial step, then stay
      for (int i = 0; i < 10; i++) cyc(0, 1, 0);
      check("R9", int'(lease), LMIN);
      cyc(0, 0, 1);
      cyc(1, 1, 1);

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         int unsigned r;
         r = $urandom_range(0, 99);
         if (r < 35)      cyc(1, 0, 0);
         else if (r < 55) cyc(0, 1, 0);
         else if (r < 70) cyc(0, 0, 1);
         else if (r < 78) cyc(0, 1, 1);
         else if (r < 86) cyc(1, $urandom_range(0, 1) == 1, 1);
         else             cyc(0, 0, 0);
      end

      // R1 mid-run reset returns to the initial lifetime
      rst_n = 1'b0;
      ld = 1'b1;
      @(negedge clk);
      ld = 1'b0;
      check("R1", int'(lease), LINIT);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(lease), LINIT);
      expv = LINIT;
      cyc(0, 0, 1);

      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run incomplete actual 0 expected 1");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule